// File: doc/BRIEF.md
# BCD Up/Down Decade Counter Digit

A single synchronous decimal digit that steps through 0 to 9 in either direction. Each rising clock edge performs one operation, chosen by priority. A synchronous clear drives the digit to zero. A parallel load writes a value from the data inputs. Otherwise the digit steps up or down when exactly one of the two count enables is high.

The digit has two wrap indicators, carry and borrow. They are combinational lookahead signals. Each is high during the cycle whose clock edge will wrap the digit, so it can drive the count enable of the next digit in a synchronous chain, in either direction. Chaining digits this way builds multi-digit decimal counters that run on a single clock.

A loaded value above 9 is not a legal BCD state. The digit leaves such a value on its next count and returns to the decimal sequence.

Top module: `bcd_updown_digit`

## Requirements
- R1: While rst_ni is low, count_o is 0. Reset is asynchronous.
- R2: When clr_i is high at a clock edge, count_o becomes 0. This happens regardless of load_i, up_i and dn_i.
- R3: When load_i is high and clr_i is low at a clock edge, count_o takes the value of load_val_i. The count enables have no effect on that edge.
- R4: With up_i high and dn_i, load_i and clr_i low, a clock edge increments count_o by one. From 9 it goes to 0.
- R5: With dn_i high and up_i, load_i and clr_i low, a clock edge decrements count_o by one. From 0 it goes to 9.
- R6: carry_o is high exactly when count_o is 9 and the condition of R4 holds. It is low at every other time.
- R7: borrow_o is high exactly when count_o is 0 and the condition of R5 holds. It is low at every other time.
- R8: When up_i and dn_i are both high, or both low, and neither clr_i nor load_i is high, count_o holds its value. In that case carry_o and borrow_o are both low.
- R9: When count_o holds a value from 10 to 15, an up step gives 0 and a down step gives 9. carry_o and borrow_o both stay low in this case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_i | input | 1 | Count-up enable |
| dn_i | input | 1 | Count-down enable |
| load_i | input | 1 | Synchronous parallel load |
| load_val_i | input | 4 | Value written by a load |
| clr_i | input | 1 | Synchronous clear to zero |
| count_o | output | 4 | Current digit value |
| carry_o | output | 1 | Lookahead carry: up step from 9 this cycle |
| borrow_o | output | 1 | Lookahead borrow: down step from 0 this cycle |

## Verification
Some behaviours are checked by assertions on every cycle. These are the clear and load results, the single steps and their wraps, the hold under conflicting or absent enables, recovery from values above 9, and the rule that carry and borrow are never high together and each one is followed by the matching wrap. Other behaviours only show up in the bench's scenarios. These include the full ten-step runs in each direction, the priority of clear over load when both are high with count enables also high, and an asynchronous reset in the middle of a cycle that is observed before the next clock edge.

// File: rtl/bcd_digit_pkg.sv
package bcd_digit_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_CLR,
    OP_LOAD,
    OP_INC,
    OP_DEC
  } op_e;
endpackage

// File: rtl/bcd_op_decode.sv
module bcd_op_decode
  import bcd_digit_pkg::*;
(
  input  logic clr_i,
  input  logic load_i,
  input  logic up_i,
  input  logic dn_i,
  output op_e  op_o
);
  // clear > load > count; conflicting enables hold
  always_comb begin
    if (clr_i)              op_o = OP_CLR;
    else if (load_i)        op_o = OP_LOAD;
    else if (up_i && !dn_i) op_o = OP_INC;
    else if (dn_i && !up_i) op_o = OP_DEC;
    else                    op_o = OP_HOLD;
  end
endmodule

// File: rtl/bcd_step.sv
module bcd_step
  import bcd_digit_pkg::*;
#(
  parameter int MODULUS = 10,
  parameter int W       = $clog2(MODULUS)
) (
  input  logic [W-1:0] cur_i,
  input  op_e          op_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] nxt_o,
  output logic         wrap_up_o,
  output logic         wrap_dn_o
);
  localparam logic [W-1:0] TOP = W'(MODULUS - 1);

  logic at_top, at_zero, over;
  assign at_top  = (cur_i == TOP);
  assign at_zero = (cur_i == '0);
  assign over    = (cur_i > TOP);

  always_comb begin
    unique case (op_i)
      OP_CLR:  nxt_o = '0;
      OP_LOAD: nxt_o = load_val_i;
      OP_INC:  nxt_o = (at_top || over) ? '0 : cur_i + W'(1);
      OP_DEC:  nxt_o = (at_zero || over) ? TOP : cur_i - W'(1);
      default: nxt_o = cur_i;
    endcase
  end

  assign wrap_up_o = (op_i == OP_INC) && at_top;
  assign wrap_dn_o = (op_i == OP_DEC) && at_zero;
endmodule

// File: rtl/bcd_updown_digit.sv
module bcd_updown_digit
  import bcd_digit_pkg::*;
#(
  parameter int MODULUS = 10,
  localparam int W      = $clog2(MODULUS)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         up_i,
  input  logic         dn_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clr_i,
  output logic [W-1:0] count_o,
  output logic         carry_o,
  output logic         borrow_o
);
  localparam logic [W-1:0] TOP = W'(MODULUS - 1);

  op_e          op;
  logic [W-1:0] cnt_q, cnt_d;

  bcd_op_decode u_dec (
    .clr_i  (clr_i),
    .load_i (load_i),
    .up_i   (up_i),
    .dn_i   (dn_i),
    .op_o   (op)
  );

  bcd_step #(.MODULUS(MODULUS), .W(W)) u_step (
    .cur_i      (cnt_q),
    .op_i       (op),
    .load_val_i (load_val_i),
    .nxt_o      (cnt_d),
    .wrap_up_o  (carry_o),
    .wrap_dn_o  (borrow_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // port-level views of the request
  logic go_up, go_dn, idle;
  assign go_up = up_i && !dn_i && !load_i && !clr_i;
  assign go_dn = dn_i && !up_i && !load_i && !clr_i;
  assign idle  = !clr_i && !load_i && (up_i == dn_i);

  a_r1_reset_zero: assert property (@(posedge clk_i) !rst_ni |-> count_o == '0);
  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_o == '0);
  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> count_o == $past(load_val_i));
  a_r4_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_up && count_o < TOP) |=> count_o == $past(count_o) + W'(1));
  a_r5_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_dn && count_o != '0 && count_o <= TOP) |=> count_o == $past(count_o) - W'(1));
  a_r6_carry_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> count_o == '0);
  a_r6_carry_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (count_o == TOP && go_up));
  a_r7_borrow_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    borrow_o |=> count_o == TOP);
  a_r7_borrow_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    borrow_o |-> (count_o == '0 && go_dn));
  a_r6_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({carry_o, borrow_o}));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> $stable(count_o));
  a_r9_over_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_up && count_o > TOP) |=> count_o == '0);
  a_r9_over_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_dn && count_o > TOP) |=> count_o == TOP);
endmodule

// File: tb/sim_bcd_updown_digit.sv
`timescale 1ns/100ps
module sim_bcd_updown_digit;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic up = 1'b0, dn = 1'b0, ld = 1'b0, clr = 1'b0;
  logic [3:0] val = 4'd0;
  logic [3:0] count;
  logic carry, borrow;

  always #2 clk = ~clk;

  bcd_updown_digit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .up_i(up), .dn_i(dn), .load_i(ld),
    .load_val_i(val), .clr_i(clr), .count_o(count), .carry_o(carry), .borrow_o(borrow)
  );

  typedef struct {
    logic [3:0] cnt;
    logic       cy;
    logic       bw;
    string      req;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  logic [3:0] model = 4'd0;
  bit done = 0;

  task automatic check(string req, logic [3:0] c, logic cy, logic bw, logic [3:0] ec, logic ecy, logic ebw);
    checks++;
    if (c !== ec || cy !== ecy || bw !== ebw) begin
      fails++;
      $display("FAIL %s: count=%0d carry=%b borrow=%b expected count=%0d carry=%b borrow=%b",
               req, c, cy, bw, ec, ecy, ebw);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected port values for it
  task automatic step(string req, logic u, logic d, logic l, logic [3:0] v, logic c);
    exp_t e;
    logic gu, gd;
    @(negedge clk);
    up = u; dn = d; ld = l; val = v; clr = c;
    #0.5;
    gu = u && !d && !l && !c;
    gd = d && !u && !l && !c;
    e.cnt = model;
    e.cy  = gu && (model == 4'd9);
    e.bw  = gd && (model == 4'd0);
    e.req = req;
    q.push_back(e);
    if (c)       model = 4'd0;
    else if (l)  model = v;
    else if (gu) model = (model >= 4'd9) ? 4'd0 : model + 4'd1;
    else if (gd) model = (model == 4'd0 || model > 4'd9) ? 4'd9 : model - 4'd1;
  endtask

  // monitor: compare the outputs with the queued expectation, away from the edge
  initial forever begin
    @(negedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.req, count, carry, borrow, e.cnt, e.cy, e.bw);
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: expired, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #5;
    check("R1", count, carry, borrow, 4'd0, 1'b0, 1'b0);
    @(negedge clk); rst_ni = 1'b1;

    // R3: load every legal digit
    for (int i = 0; i < 10; i++) step("R3", 0, 0, 1, 4'(i), 0);
    // R4/R6: up run across the wrap
    step("R3", 0, 0, 1, 4'd5, 0);
    for (int i = 0; i < 12; i++) step("R4_R6", 1, 0, 0, 4'd0, 0);
    // R5/R7: down run across the wrap
    step("R3", 0, 0, 1, 4'd3, 0);
    for (int i = 0; i < 12; i++) step("R5_R7", 0, 1, 0, 4'd0, 0);
    // R8: conflicting and absent enables at the wrap points
    step("R3", 0, 0, 1, 4'd9, 0);
    step("R8", 1, 1, 0, 4'd0, 0);
    step("R8", 0, 0, 0, 4'd0, 0);
    step("R3", 0, 0, 1, 4'd0, 0);
    step("R8", 1, 1, 0, 4'd0, 0);
    step("R8", 0, 0, 0, 4'd0, 0);
    // R2: clear beats load and count
    step("R3", 0, 0, 1, 4'd7, 0);
    step("R2", 1, 0, 1, 4'd4, 1);
    step("R2", 0, 0, 0, 4'd0, 0);
    step("R3", 0, 0, 1, 4'd6, 0);
    step("R2", 0, 1, 0, 4'd0, 1);
    step("R2", 0, 0, 0, 4'd0, 0);
    // R3: load beats count, also at 9 with up (no carry)
    step("R3", 0, 0, 1, 4'd9, 0);
    step("R3", 1, 0, 1, 4'd2, 0);
    step("R3", 0, 1, 1, 4'd0, 0);
    step("R3", 0, 0, 0, 4'd0, 0);
    // R9: out-of-range recovery
    step("R9", 0, 0, 1, 4'd12, 0);
    step("R9", 1, 0, 0, 4'd0, 0);
    step("R9", 0, 0, 0, 4'd0, 0);
    step("R9", 0, 0, 1, 4'd15, 0);
    step("R9", 0, 1, 0, 4'd0, 0);
    step("R9", 0, 0, 0, 4'd0, 0);
    step("R9", 0, 0, 1, 4'd10, 0);
    step("R9", 1, 1, 0, 4'd0, 0);
    step("R9", 0, 1, 0, 4'd0, 0);
    step("R9", 0, 0, 0, 4'd0, 0);
    // drain
    step("R8", 0, 0, 0, 4'd0, 0);
    @(negedge clk); @(negedge clk);
    // R1: asynchronous reset mid-cycle
    up = 0; dn = 0; ld = 1; val = 4'd8; clr = 0;
    @(negedge clk); ld = 0;
    #0.5 rst_ni = 1'b0;
    #0.5 check("R1", count, carry, borrow, 4'd0, 1'b0, 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule